// File: doc/BRIEF.md
# Synchronous Master Serial Receiver

This block is the receive half of a half-duplex synchronous serial port that acts as the clock master. Only while a reception is wanted, it drives a shift clock on `sck_o` at a rate set by a divider register. It samples `sdat_i` on each falling edge of that clock and collects words of eight or nine bits, least significant bit first. Completed words go into a two-entry receive buffer that software drains through a pop strobe.

Software controls the block through a small write port. Address 0 holds the control bits and address 1 holds the clock divider. A single-word request fetches exactly one word and then clears itself. A continuous request keeps fetching words back to back until software clears it. A ready flag, an optional interrupt, a ninth-bit output and an overrun flag report the receive state. An overrun stops all clocking until software clears it.

Top module: `srx_master`

## Requirements
- R1: After a synchronous active-low reset, `sck_o`, `rx_ready`, `rx_irq` and `rx_overrun` are 0, and `ctrl_rd` reads 0.
- R2: Clocking runs only while control bit 0 (port enable) and control bit 1 (master select) are both 1, at least one receive request (bit 2 or bit 3) is 1, and no overrun is pending. Otherwise `sck_o` stays low.
- R3: Each bit period starts with `sck_o` low for DIV+1 cycles and then has it high for DIV+1 cycles, where DIV is the value at address 1. `sdat_i` is sampled when `sck_o` falls, and the first sampled bit lands in data bit 0.
- R4: Writing control bit 2 (single request) fetches one word. `rx_ready` rises 2*W*(DIV+1)+2 cycles after the write edge, where W is the word length. Bit 2 then reads back as 0 and `sck_o` stays low.
- R5: With control bit 3 (continuous request) set, words follow one another without a gap. Clearing bit 3 stops the clock.
- R6: When bits 2 and 3 are both set, continuous operation wins. More than one word is received, and bit 2 is not cleared.
- R7: With control bit 4 set, words are nine bits long. The ninth sampled bit appears on `rx_bit8` for the word at the buffer head. In 8-bit mode `rx_bit8` is 0.
- R8: The buffer holds two words in arrival order. `rx_ready` is high while the buffer holds a word. A `data_pop` pulse removes the head word.
- R9: `rx_irq` equals `rx_ready` AND control bit 5 (interrupt enable).
- R10: If a word completes while two words are held, `rx_overrun` is set, that word is discarded, and `sck_o` stays low from then on.
- R11: A control write with bit 3 equal to 0 clears `rx_overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control, 1 = divider |
| reg_wdata | input | 8 | Write data |
| data_pop | input | 1 | Removes the head word from the buffer |
| sdat_i | input | 1 | Serial data from the link |
| sck_o | output | 1 | Generated shift clock, idles low |
| ctrl_rd | output | 8 | Control register readback |
| rx_data | output | 8 | Low eight bits of the head word |
| rx_bit8 | output | 1 | Ninth bit of the head word |
| rx_ready | output | 1 | Buffer holds a word |
| rx_overrun | output | 1 | Overrun error |
| rx_irq | output | 1 | Receive interrupt |

## Verification
A single-word request puts its word in the buffer exactly 2*W*(DIV+1)+2 cycles after the control write edge. The bench samples `rx_ready` one cycle before and at that count, so an early or late flag is caught. Serial data comes from a bench slave that changes `sdat_i` after each rising edge of `sck_o`, so the data is stable at the falling edge whatever the divider. Clock half-periods are measured edge to edge. Effects of a control write or a pop appear one cycle later, and the bench samples them on the following falling clock edge. Continuous and overrun runs have no fixed length, so the bench polls with a bounded wait and then checks the buffer contents and order.

// File: rtl/srx_pkg.sv
// Shared types for the synchronous master receiver.
// Assumes the control register is written as one byte; field order fixes bit positions.
package srx_pkg;
    typedef struct packed {
        logic irq_en;   // bit 5
        logic nine;     // bit 4
        logic cont;     // bit 3
        logic single;   // bit 2
        logic master;   // bit 1
        logic port_en;  // bit 0
    } srx_ctrl_t;

    localparam int CTRL_W   = $bits(srx_ctrl_t);
    localparam int CONT_BIT = 3;

    typedef enum logic {SH_IDLE, SH_SHIFT} sh_state_t;
endpackage

// File: rtl/srx_regs.sv
// Control, divider and overrun-status registers.
// Assumes word_done and ovr_evt are single-cycle pulses; a software write wins over self-clear.
module srx_regs
    import srx_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             addr,
    input  logic [REG_W-1:0] wdata,
    input  logic             word_done,
    input  logic             ovr_evt,
    output srx_ctrl_t        ctrl,
    output logic [DIV_W-1:0] div,
    output logic             ovr
);
    logic unused_wdata;
    assign unused_wdata = &{1'b0, wdata};

    // Control register: software write, or hardware clear of the single request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl <= '0;
        else if (wr && !addr)
            ctrl <= srx_ctrl_t'(wdata[CTRL_W-1:0]);
        else if (word_done && !ctrl.cont)
            ctrl.single <= 1'b0;
    end

    // Divider register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            div <= '0;
        else if (wr && addr)
            div <= wdata[DIV_W-1:0];
    end

    // Overrun flag: set by a dropped word, cleared by a control write with continuous off.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovr <= 1'b0;
        else if (ovr_evt)
            ovr <= 1'b1;
        else if (wr && !addr && !wdata[CONT_BIT])
            ovr <= 1'b0;
    end

    AST_SINGLE_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && !ctrl.cont && !wr) |=> !ctrl.single);  // R4
endmodule

// File: rtl/srx_shifter.sv
// Shift-clock generator and receive shift register.
// Assumes run drops to abort; the clock idles low and each half-period is div+1 cycles.
// Bits are sampled at the falling edge, LSB first; cont_i picks whether to go on after a word.
module srx_shifter
    import srx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             cont_i,
    input  logic             nine,
    input  logic [DIV_W-1:0] div,
    input  logic             sdat_i,
    output logic             sck_o,
    output logic             done_o,
    output logic [DATA_W:0]  word_o
);
    localparam int WW = DATA_W + 1;
    localparam int IW = $clog2(WW);
    localparam logic [IW-1:0] LAST9 = IW'(DATA_W);
    localparam logic [IW-1:0] LAST8 = IW'(DATA_W - 1);

    sh_state_t        st;
    logic [DIV_W-1:0] cnt;
    logic [IW-1:0]    bitn;
    logic [WW-1:0]    shreg, sh_next;
    logic [IW-1:0]    last_idx;

    // Next shift contents with the current input bit placed at its index.
    always_comb begin
        sh_next       = shreg;
        sh_next[bitn] = sdat_i;
        last_idx      = nine ? LAST9 : LAST8;
    end

    // Half-period counter, clock toggling, bit capture and word completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= SH_IDLE;
            cnt    <= '0;
            bitn   <= '0;
            shreg  <= '0;
            sck_o  <= 1'b0;
            done_o <= 1'b0;
            word_o <= '0;
        end else begin
            done_o <= 1'b0;
            if (!run) begin
                st    <= SH_IDLE;
                sck_o <= 1'b0;
                cnt   <= '0;
                bitn  <= '0;
            end else if (st == SH_IDLE) begin
                st    <= SH_SHIFT;
                sck_o <= 1'b0;
                cnt   <= '0;
                bitn  <= '0;
                shreg <= '0;
            end else if (cnt != div) begin
                cnt <= cnt + 1'b1;
            end else begin
                cnt   <= '0;
                sck_o <= ~sck_o;
                if (sck_o) begin
                    if (bitn >= last_idx) begin
                        done_o <= 1'b1;
                        word_o <= nine ? sh_next : {1'b0, sh_next[DATA_W-1:0]};
                        bitn   <= '0;
                        shreg  <= '0;
                        if (!cont_i)
                            st <= SH_IDLE;
                    end else begin
                        bitn  <= bitn + 1'b1;
                        shreg <= sh_next;
                    end
                end
            end
        end
    end

    AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $fell(sck_o));  // R3
    AST_IDLE_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SH_IDLE) |-> !sck_o);  // R2
endmodule

// File: rtl/srx_fifo.sv
// Small receive buffer, first in first out.
// Assumes the caller never pushes when full and never pops when empty.
module srx_fifo #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wptr, rptr;
    logic [CW-1:0]    count;

    // Entry storage, cleared at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (push) begin
            mem[wptr] <= din;
        end
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= (wptr == PTR_LAST) ? '0 : wptr + 1'b1;
            if (pop)  rptr <= (rptr == PTR_LAST) ? '0 : rptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign dout  = mem[rptr];
    assign empty = (count == '0);
    assign full  = (count == CNT_FULL);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);  // R10
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);  // R8
endmodule

// File: rtl/srx_master.sv
// Top of the synchronous master receiver: registers, clock/shift engine and buffer.
// Assumes one write port (address 0 control, 1 divider) and a pop strobe for reading.
module srx_master
    import srx_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int DIV_W     = 8,
    parameter int BUF_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              data_pop,
    input  logic              sdat_i,
    output logic              sck_o,
    output logic [7:0]        ctrl_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_bit8,
    output logic              rx_ready,
    output logic              rx_overrun,
    output logic              rx_irq
);
    localparam int WW = DATA_W + 1;

    srx_ctrl_t        ctrl;
    logic [DIV_W-1:0] div;
    logic             run, keep_on, done, push, pop, ovr_evt;
    logic             buf_empty, buf_full;
    logic [WW-1:0]    word, head;

    srx_regs #(.DIV_W(DIV_W), .REG_W(8)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .word_done(done), .ovr_evt(ovr_evt), .ctrl(ctrl), .div(div), .ovr(rx_overrun)
    );

    // Receive gating and the decision to run on after a word.
    always_comb begin
        run     = ctrl.port_en && ctrl.master && (ctrl.single || ctrl.cont) && !rx_overrun;
        keep_on = ctrl.cont && !buf_full;
        push    = done && !buf_full;
        ovr_evt = done && buf_full;
        pop     = data_pop && !buf_empty;
    end

    srx_shifter #(.DATA_W(DATA_W), .DIV_W(DIV_W)) i_shift (
        .clk(clk), .rst_n(rst_n), .run(run), .cont_i(keep_on), .nine(ctrl.nine),
        .div(div), .sdat_i(sdat_i), .sck_o(sck_o), .done_o(done), .word_o(word)
    );

    srx_fifo #(.WIDTH(WW), .DEPTH(BUF_DEPTH)) i_buf (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .din(word),
        .dout(head), .empty(buf_empty), .full(buf_full)
    );

    // Readback and status outputs.
    always_comb begin
        ctrl_rd  = 8'(ctrl);
        rx_data  = head[DATA_W-1:0];
        rx_bit8  = head[DATA_W] && !buf_empty;
        rx_ready = !buf_empty;
        rx_irq   = rx_ready && ctrl.irq_en;
    end

    AST_GATED_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !sck_o);  // R2
    AST_OVR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |-> !sck_o);  // R10
    AST_IRQ_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> rx_ready);  // R9
endmodule

// File: tb/test_srx_master.sv
// Bench for srx_master: a serial slave model plus directed and seeded random cases.
module test_srx_master;
    localparam int C_PORT = 1, C_MAST = 2, C_SGL = 4, C_CONT = 8, C_NINE = 16, C_IRQ = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_addr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic       data_pop = 1'b0;
    logic       sdat = 1'b0;
    logic       sck_o, rx_bit8, rx_ready, rx_overrun, rx_irq;
    logic [7:0] ctrl_rd, rx_data;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;
    logic stream [0:4095];
    int sptr = 0, wp = 0;
    logic sck_prev = 1'b0;

    always #2 clk = ~clk;

    srx_master i_srx_master (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .data_pop(data_pop), .sdat_i(sdat), .sck_o(sck_o),
        .ctrl_rd(ctrl_rd), .rx_data(rx_data), .rx_bit8(rx_bit8), .rx_ready(rx_ready),
        .rx_overrun(rx_overrun), .rx_irq(rx_irq)
    );

    // Slave: present the next stream bit after each rising shift-clock edge.
    always @(negedge clk) begin
        if (sck_o && !sck_prev) begin
            sdat <= stream[sptr];
            sptr <= sptr + 1;
        end
        sck_prev <= sck_o;
    end

    function automatic int ready_delay(int w, int d);
        return 2 * w * (d + 1) + 2;
    endfunction

    function automatic int expect_word(int w, int nine);
        return nine ? (w & 9'h1FF) : (w & 8'hFF);
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_reg(bit a, int v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = 8'(v);
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pop_one();
        @(negedge clk);
        data_pop = 1'b1;
        @(posedge clk);
        @(negedge clk);
        data_pop = 1'b0;
    endtask

    task automatic load(int w, int nbits);
        for (int i = 0; i < nbits; i++) begin
            stream[wp] = w[i];
            wp++;
        end
    endtask

    task automatic sync_stream();
        @(negedge clk);
        wp = sptr;
    endtask

    task automatic count_high(int n, output int highs);
        highs = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (sck_o) highs++;
        end
    endtask

    task automatic wait_ready(int limit);
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (rx_ready) break;
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int highs, lows, t, d, nine, w, irq, words[3];
        int unsigned seed;
        for (int i = 0; i < 4096; i++) stream[i] = 1'b0;
        seed = $urandom(32'd2024);
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 sck", int'(sck_o), 0);
        chk("R1 ready", int'(rx_ready), 0);
        chk("R1 irq", int'(rx_irq), 0);
        chk("R1 ovr", int'(rx_overrun), 0);
        chk("R1 ctrl", int'(ctrl_rd), 0);

        // R2: gating by port enable, master select and requests
        wr_reg(1'b1, 0);
        wr_reg(1'b0, C_MAST | C_CONT);
        count_high(60, highs);
        chk("R2 no port enable", highs, 0);
        wr_reg(1'b0, C_PORT | C_CONT);
        count_high(60, highs);
        chk("R2 no master", highs, 0);
        wr_reg(1'b0, C_PORT | C_MAST);
        count_high(60, highs);
        chk("R2 no request", highs + int'(rx_ready), 0);

        // R3: half periods and bit order, divider 3
        sync_stream();
        load(8'hA5, 8);
        wr_reg(1'b1, 3);
        wr_reg(1'b0, C_PORT | C_MAST | C_SGL);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (sck_o) break;
        end
        highs = 0;
        while (sck_o) begin highs++; @(negedge clk); end
        lows = 0;
        while (!sck_o) begin lows++; @(negedge clk); end
        chk("R3 high half", highs, 4);
        chk("R3 low half", lows, 4);
        wait_ready(200);
        chk("R3 data lsb first", int'(rx_data), 8'hA5);
        pop_one();

        // R4 R7 R9: seeded random single-word receptions with exact timing
        for (int k = 0; k < 20; k++) begin
            d    = int'($urandom % 4);
            nine = int'($urandom % 2);
            irq  = int'($urandom % 2);
            w    = int'($urandom % 512);
            if (k == 0) begin d = 0; nine = 1; w = 9'h155; end
            sync_stream();
            load(w, nine ? 9 : 8);
            wr_reg(1'b1, d);
            wr_reg(1'b0, C_PORT | C_MAST | C_SGL | (nine ? C_NINE : 0) | (irq ? C_IRQ : 0));
            t = ready_delay(nine ? 9 : 8, d);
            repeat (t - 1) @(posedge clk);
            @(negedge clk);
            chk("R4 ready not early", int'(rx_ready), 0);
            @(posedge clk);
            @(negedge clk);
            chk("R4 ready on time", int'(rx_ready), 1);
            chk("R3 data", int'(rx_data), expect_word(w, nine) & 8'hFF);
            chk("R7 ninth bit", int'(rx_bit8), expect_word(w, nine) >> 8);
            chk("R9 irq", int'(rx_irq), irq);
            chk("R4 single self-clear", (int'(ctrl_rd) >> 2) & 1, 0);
            count_high(3 * (d + 1) + 4, highs);
            chk("R4 clock stopped", highs, 0);
            pop_one();
            chk("R8 empty after pop", int'(rx_ready), 0);
        end

        // R9: interrupt follows enable while a word waits
        sync_stream();
        load(8'h3C, 8);
        wr_reg(1'b1, 1);
        wr_reg(1'b0, C_PORT | C_MAST | C_SGL | C_IRQ);
        wait_ready(200);
        chk("R9 irq on", int'(rx_irq), 1);
        wr_reg(1'b0, C_PORT | C_MAST);
        chk("R9 irq masked", int'(rx_irq), 0);
        chk("R9 ready kept", int'(rx_ready), 1);
        pop_one();

        // R10 R5 R8: continuous fill, overrun, order and drop
        words[0] = 8'h11; words[1] = 8'hE7; words[2] = 8'h5A;
        sync_stream();
        for (int i = 0; i < 3; i++) load(words[i], 8);
        wr_reg(1'b1, 1);
        wr_reg(1'b0, C_PORT | C_MAST | C_CONT);
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (rx_overrun) break;
        end
        chk("R10 overrun set", int'(rx_overrun), 1);
        count_high(50, highs);
        chk("R10 clock halted", highs, 0);
        chk("R8 first word", int'(rx_data), words[0]);
        pop_one();
        chk("R8 second still ready", int'(rx_ready), 1);
        chk("R8 second word", int'(rx_data), words[1]);
        pop_one();
        chk("R10 third dropped", int'(rx_ready), 0);
        wr_reg(1'b0, C_PORT | C_MAST);
        chk("R11 overrun cleared", int'(rx_overrun), 0);

        // R6 R5: both requests set, continuous wins, then stop
        sync_stream();
        load(8'hC3, 8);
        load(8'h96, 8);
        wr_reg(1'b1, 0);
        wr_reg(1'b0, C_PORT | C_MAST | C_SGL | C_CONT);
        wait_ready(200);
        chk("R6 word one", int'(rx_data), 8'hC3);
        pop_one();
        wait_ready(200);
        chk("R6 word two", int'(rx_data), 8'h96);
        chk("R6 single kept", (int'(ctrl_rd) >> 2) & 1, 1);
        wr_reg(1'b0, C_PORT | C_MAST);
        count_high(40, highs);
        chk("R5 stop on clear", highs, 0);
        while (rx_ready) pop_one();
        chk("R8 drained", int'(rx_ready), 0);

        finished = 1;
        summary();
        $finish;
    end
endmodule